// File: doc/BRIEF.md
# Receive Gain Control Loop

This block is the digital automatic gain control for a receive chain in which a programmable-gain amplifier feeds an ADC. It watches the signed ADC samples, takes the largest magnitude seen over a fixed-length window, and moves a gain code one step up or down so that the converter input sits in its best range. The code selects one of nine settings, 6 dB apart, from -18 dB (code 0) to +30 dB (code 8). Each step up halves the input swing the amplifier accepts before the ADC clips.

A freeze input holds the gain steady, for example while a frame is being received. A strobe marks every cycle in which the code moves. After every change the next full window is dropped, so that the analog path can settle before it is measured again.

Top module: `rx_gain_loop`

## Requirements
- R1: Reset sets the gain code to 3 (0 dB) and holds the change strobe low.
- R2: A decision is made only on the valid sample that completes a window of WIN_LEN valid samples. Cycles with `smp_valid` low neither count nor feed the peak.
- R3: When the window peak magnitude is strictly above 7/8 of full scale (2^(SAMPLE_W-1)), the code falls by one.
- R4: When the window peak magnitude is strictly below 3/8 of full scale, the code rises by one.
- R5: A peak from 3/8 to 7/8 of full scale, both limits included, leaves the code unchanged.
- R6: The code stays within 0 to 8 and never wraps. A request beyond either end is dropped without a strobe.
- R7: The window that follows a code change is discarded and makes no decision.
- R8: While `freeze` is high the code is held and the window restarts. The first decision after release uses only samples taken after release.
- R9: `gain_step` is high for exactly the one cycle in which `gain_code` takes its new value. The code moves by at most one per change.
- R10: Samples are two's complement. A negative sample counts by its magnitude, and the most negative value counts as full scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | ADC sample valid |
| smp_data | input | SAMPLE_W | Two's-complement ADC sample |
| freeze | input | 1 | Hold gain and restart the window |
| gain_code | output | 4 | PGA gain code, 0..8 |
| gain_step | output | 1 | One-cycle pulse when gain_code changes |

## Verification
A fault in the window counter, the peak register or the discard flag can only show at the ports as a gain move made one window too early or too late. A move can also appear when none is due, or go missing when one is due. The bench therefore predicts every window's outcome and compares the code and the strobe on the cycle right after each window's final sample, so a fault shows within one window. Threshold edges, both saturation ends, negative full scale and freeze in the middle of a window are each driven at that window resolution.

// File: rtl/rx_gain_loop.sv
module rx_gain_loop #(
  parameter int SAMPLE_W   = 12,
  parameter int WIN_LEN    = 256,
  parameter int MAX_CODE   = 8,
  parameter int RESET_CODE = 3,
  parameter int CODE_W     = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                freeze,
  output logic [CODE_W-1:0]   gain_code,
  output logic                gain_step
);
  localparam int CNT_W  = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
  localparam int FULL_I = 2 ** (SAMPLE_W - 1);
  localparam logic [SAMPLE_W-1:0] HI_TH = SAMPLE_W'(FULL_I * 7 / 8);
  localparam logic [SAMPLE_W-1:0] LO_TH = SAMPLE_W'(FULL_I * 3 / 8);
  localparam logic [CNT_W-1:0]    LAST  = CNT_W'(WIN_LEN - 1);
  localparam logic [CODE_W-1:0]   TOP   = CODE_W'(MAX_CODE);
  localparam logic [CODE_W-1:0]   INIT  = CODE_W'(RESET_CODE);

  logic [CNT_W-1:0]    cnt;
  logic [SAMPLE_W-1:0] peak, mag, pk_now;
  logic                skip;
  logic                go_down, go_up;

  assign mag     = smp_data[SAMPLE_W-1] ? (~smp_data + 1'b1) : smp_data;
  assign pk_now  = (mag > peak) ? mag : peak;
  assign go_down = (pk_now > HI_TH) && (gain_code != '0);
  assign go_up   = (pk_now < LO_TH) && (gain_code != TOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      peak      <= '0;
      skip      <= 1'b0;
      gain_code <= INIT;
      gain_step <= 1'b0;
    end else begin
      gain_step <= 1'b0;
      if (freeze) begin
        cnt  <= '0;
        peak <= '0;
      end else if (smp_valid) begin
        if (cnt == LAST) begin
          cnt  <= '0;
          peak <= '0;
          if (skip) begin
            skip <= 1'b0;
          end else if (go_down) begin
            gain_code <= gain_code - 1'b1;
            gain_step <= 1'b1;
            skip      <= 1'b1;
          end else if (go_up) begin
            gain_code <= gain_code + 1'b1;
            gain_step <= 1'b1;
            skip      <= 1'b1;
          end
        end else begin
          cnt  <= cnt + 1'b1;
          peak <= pk_now;
        end
      end
    end
  end

  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    gain_code <= TOP);  // R6
  AST_CHANGE_STROBED: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_code != $past(gain_code)) |-> gain_step);  // R9
  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    gain_step |-> (gain_code == $past(gain_code) + CODE_W'(1)) ||
                  (gain_code == $past(gain_code) - CODE_W'(1)));  // R9
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(gain_code));  // R8
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    gain_step |=> !gain_step);  // R7
endmodule

// File: tb/rx_gain_loop_tb.sv
module rx_gain_loop_tb;
  localparam int W   = 8;
  localparam int WIN = 8;
  localparam int HI  = 112;
  localparam int LO  = 48;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         smp_valid = 1'b0;
  logic [W-1:0] smp_data = '0;
  logic         freeze = 1'b0;
  logic [3:0]   gain_code;
  logic         gain_step;

  int checks = 0;
  int failures = 0;
  int exp_code = 3;
  bit exp_skip = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rx_gain_loop #(.SAMPLE_W(W), .WIN_LEN(WIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .freeze(freeze), .gain_code(gain_code), .gain_step(gain_step));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      smp_valid = 1'b0;
      smp_data  = 8'h80;
    end
  endtask

  task automatic window(input int pk, input bit neg, input string req);
    bit chg;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      smp_valid = 1'b1;
      if (i == WIN / 2) smp_data = neg ? W'(-pk) : W'(pk);
      else smp_data = W'((i % 3) * pk / 4);
      if (i == WIN - 1) begin
        chk(gain_code == 4'(exp_code) && !gain_step, "R2 no early decision",
            int'(gain_code), exp_code);
      end
    end
    chg = 1'b0;
    if (exp_skip) exp_skip = 1'b0;
    else if (pk > HI && exp_code > 0) begin exp_code--; chg = 1'b1; end
    else if (pk < LO && exp_code < 8) begin exp_code++; chg = 1'b1; end
    if (chg) exp_skip = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    chk(gain_code == 4'(exp_code), {req, " code"}, int'(gain_code), exp_code);
    chk(gain_step == chg, {"R9 strobe ", req}, int'(gain_step), int'(chg));
    @(negedge clk);
    chk(!gain_step, "R9 strobe one cycle", int'(gain_step), 0);
    idle(2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(gain_code == 4'd3, "R1 code in reset", int'(gain_code), 3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(gain_code == 4'd3 && !gain_step, "R1 after reset", int'(gain_code), 3);

    window(80, 0, "R5 mid");
    window(112, 0, "R5 upper edge");
    window(113, 0, "R3 above upper");
    window(120, 0, "R7 discarded");
    window(128, 1, "R10 negative full scale");
    window(30, 0, "R7 discarded");
    window(127, 0, "R3 down");
    window(127, 0, "R7 discarded");
    window(127, 0, "R6 floor");
    window(127, 1, "R6 floor again");
    window(48, 0, "R5 lower edge");
    window(47, 1, "R4 below lower");
    for (int n = 0; n < 16; n++) window(10, n[0], "R4 climb");
    window(0, 0, "R6 ceiling");
    window(5, 0, "R6 ceiling again");

    for (int a = 100; a <= 127; a += 9) window(a, 0, "R3 R5 sweep");

    // R8: large samples before freeze must not reach the next decision
    for (int i = 0; i < WIN / 2; i++) begin
      @(negedge clk); smp_valid = 1'b1; smp_data = 8'h80;
    end
    @(negedge clk); freeze = 1'b1; smp_data = 8'h81;
    for (int i = 0; i < WIN + 2; i++) @(negedge clk);
    chk(!gain_step, "R8 no strobe while frozen", int'(gain_step), 0);
    chk(gain_code == 4'(exp_code), "R8 held while frozen", int'(gain_code), exp_code);
    @(negedge clk); freeze = 1'b0; smp_valid = 1'b0;
    window(80, 0, "R8 window restarted");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule